// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables from memory. Each privilege mode has its own top-level table, found through a base frame number that the surrounding logic supplies. The top 10 address bits select a 4-byte directory word in that table. A valid directory word names the frame of one page of leaf words. The next 10 address bits select one leaf word in that page, and that word maps a 4 KB page.

A client presents one request at a time: an address, a mode flag and a write flag. The block answers with the physical address, a cache-inhibit hint and one of three fault flags. The first fault flag reports a missing directory entry. The second reports a missing page. The third reports a write to a page that is read-only.

The walker keeps the usage bits in the leaf words up to date. When a translation succeeds, it marks the page as referenced, and on a write it also marks the page as modified. It writes the leaf word back to memory only when one of those bits was clear before.

Top module: `xlat_walk`

## Requirements
- R1: The first read goes to {base, vaddr[31:22], 2'b00}, with the 20-bit base frame `sup_base` when `req_super` is 1 and `usr_base` when it is 0. The base is sampled in the cycle the request is accepted, so changing a base input later has no effect on a walk already in progress.
- R2: A directory word is usable only when bit 1 (valid) is 1, bit 3 is 1 and bits 11:4 are all zero. Any other directory word ends the walk with `rsp_flt_table` set, and no second read is issued.
- R3: The second read goes to {directory word[31:12], vaddr[21:12], 2'b00}.
- R4: A leaf word whose bit 0 (valid) is 0 ends the walk with `rsp_flt_page` set and no write to memory.
- R5: A write request fails with `rsp_flt_prot` set, and no write to memory, when bit 2 (read-only) is set in either the directory word or the leaf word. A read request is not affected by either read-only bit.
- R6: On success, `rsp_paddr` = {leaf word[31:12], vaddr[11:0]} and `rsp_nocache` equals bit 6 of the leaf word. When any fault flag is set, `rsp_paddr` and `rsp_nocache` are zero.
- R7: On success the leaf word gets bit 3 (referenced) set, and a write request also gets bit 4 (modified) set. The updated word is written to the leaf address only when this changes the word. Otherwise there is no write at all.
- R8: `req_ready` is 1 only while no request is in progress. `rsp_valid`, together with its data, is held unchanged until `rsp_ready` is 1.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_write` and `mem_wdata` stay unchanged. Read data is taken in the cycle where `mem_valid` and `mem_ready` are both 1.
- R10: At most one fault flag is set in any response.
- R11: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_super | input | 1 | 1 = supervisor table, 0 = user table |
| req_write | input | 1 | 1 = write access |
| sup_base | input | 20 | Frame of the supervisor directory page |
| usr_base | input | 20 | Frame of the user directory page |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_nocache | output | 1 | Page is marked cache-inhibited |
| rsp_flt_table | output | 1 | Directory entry missing or malformed |
| rsp_flt_page | output | 1 | Leaf entry not valid |
| rsp_flt_prot | output | 1 | Write to a read-only segment or page |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_write | output | 1 | 1 = write leaf word back |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is 1 |

## Verification
The bench builds the walker with its default parameters: a 32-bit address and a 12-bit offset, which leave two 10-bit indices. This makes the highest directory and leaf indices, 0x3FF, reachable, as well as both mode tables at once. The memory and the response side both stall on a repeating pattern, so the hold rules are tested while a walk is in the directory read, the leaf read, the write-back and the response. Each directory word shape, each leaf bit combination and a base change during a walk each get their own transaction.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int DIR_VALID_BIT  = 1;
  localparam int DIR_RO_BIT     = 2;
  localparam int DIR_ONE_BIT    = 3;
  localparam int LEAF_VALID_BIT = 0;
  localparam int LEAF_RO_BIT    = 2;
  localparam int LEAF_REF_BIT   = 3;
  localparam int LEAF_MOD_BIT   = 4;
  localparam int LEAF_NC_BIT    = 6;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR,
    WS_LEAF,
    WS_WBACK,
    WS_RESP
  } walk_state_e;

  typedef enum logic [1:0] {
    FT_NONE,
    FT_TABLE,
    FT_PAGE,
    FT_PROT
  } fault_e;

endpackage

// File: rtl/xw_dir_check.sv
module xw_dir_check
  import xw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic [WORD_W-1:0] dir_word,
  output logic              dir_ok,
  output logic              dir_ro
);

  logic unused_bits;
  assign unused_bits = dir_word[0] ^ (^dir_word[WORD_W-1:PAGE_W]);

  always_comb begin
    dir_ok = dir_word[DIR_VALID_BIT] && dir_word[DIR_ONE_BIT]
             && (dir_word[PAGE_W-1:4] == '0);
    dir_ro = dir_word[DIR_RO_BIT];
  end

endmodule

// File: rtl/xw_leaf_eval.sv
module xw_leaf_eval
  import xw_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] leaf_word,
  input  logic              is_write,
  input  logic              seg_ro,
  output fault_e            leaf_fault,
  output logic [WORD_W-1:0] leaf_next,
  output logic              leaf_dirty
);

  logic [WORD_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[LEAF_REF_BIT] = 1'b1;
    set_mask[LEAF_MOD_BIT] = is_write;

    if (!leaf_word[LEAF_VALID_BIT])
      leaf_fault = FT_PAGE;
    else if (is_write && (seg_ro || leaf_word[LEAF_RO_BIT]))
      leaf_fault = FT_PROT;
    else
      leaf_fault = FT_NONE;

    leaf_next  = leaf_word | set_mask;
    leaf_dirty = (leaf_fault == FT_NONE) && (leaf_next != leaf_word);
  end

endmodule

// File: rtl/xw_walk_ctl.sv
module xw_walk_ctl
  import xw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_super,
  input  logic              req_write,
  input  logic [ADDR_W-PAGE_W-1:0] sup_base,
  input  logic [ADDR_W-PAGE_W-1:0] usr_base,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              dir_ok,
  input  logic              dir_ro,
  input  fault_e            leaf_fault,
  input  logic [ADDR_W-1:0] leaf_next,
  input  logic              leaf_dirty,
  output logic              cur_write,
  output logic              cur_seg_ro,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_nocache,
  output logic              rsp_flt_table,
  output logic              rsp_flt_page,
  output logic              rsp_flt_prot
);

  localparam int FRAME_W = ADDR_W - PAGE_W;
  localparam int IDX_W   = PAGE_W - 2;

  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] va_q, va_d;
  logic              wr_q, wr_d;
  logic [FRAME_W-1:0] base_q, base_d;
  logic [FRAME_W-1:0] pt_frame_q, pt_frame_d;
  logic              sro_q, sro_d;
  logic [ADDR_W-1:0] leaf_q, leaf_d;
  fault_e            flt_q, flt_d;

  logic [ADDR_W-1:0] dir_addr, leaf_addr;
  logic              mem_fire;

  assign dir_addr  = {base_q, va_q[ADDR_W-1 -: IDX_W], 2'b00};
  assign leaf_addr = {pt_frame_q, va_q[PAGE_W +: IDX_W], 2'b00};

  always_comb begin
    mem_valid = (st_q == WS_DIR) || (st_q == WS_LEAF) || (st_q == WS_WBACK);
    mem_write = (st_q == WS_WBACK);
    mem_addr  = (st_q == WS_DIR) ? dir_addr : leaf_addr;
    mem_wdata = leaf_q;
    mem_fire  = mem_valid && mem_ready;
    req_ready = (st_q == WS_IDLE);
    cur_write  = wr_q;
    cur_seg_ro = sro_q;
  end

  always_comb begin
    rsp_valid     = (st_q == WS_RESP);
    rsp_flt_table = (flt_q == FT_TABLE);
    rsp_flt_page  = (flt_q == FT_PAGE);
    rsp_flt_prot  = (flt_q == FT_PROT);
    if (flt_q == FT_NONE) begin
      rsp_paddr   = {leaf_q[ADDR_W-1:PAGE_W], va_q[PAGE_W-1:0]};
      rsp_nocache = leaf_q[LEAF_NC_BIT];
    end else begin
      rsp_paddr   = '0;
      rsp_nocache = 1'b0;
    end
  end

  // next-state logic
  always_comb begin
    st_d       = st_q;
    va_d       = va_q;
    wr_d       = wr_q;
    base_d     = base_q;
    pt_frame_d = pt_frame_q;
    sro_d      = sro_q;
    leaf_d     = leaf_q;
    flt_d      = flt_q;
    case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          va_d   = req_vaddr;
          wr_d   = req_write;
          base_d = req_super ? sup_base : usr_base;
          flt_d  = FT_NONE;
          st_d   = WS_DIR;
        end
      end
      WS_DIR: begin
        if (mem_fire) begin
          pt_frame_d = mem_rdata[ADDR_W-1:PAGE_W];
          sro_d      = dir_ro;
          if (dir_ok) begin
            st_d = WS_LEAF;
          end else begin
            flt_d = FT_TABLE;
            st_d  = WS_RESP;
          end
        end
      end
      WS_LEAF: begin
        if (mem_fire) begin
          leaf_d = leaf_next;
          flt_d  = leaf_fault;
          st_d   = leaf_dirty ? WS_WBACK : WS_RESP;
        end
      end
      WS_WBACK: begin
        if (mem_fire) st_d = WS_RESP;
      end
      WS_RESP: begin
        if (rsp_ready) st_d = WS_IDLE;
      end
      default: st_d = WS_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= WS_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      base_q     <= '0;
      pt_frame_q <= '0;
      sro_q      <= 1'b0;
      leaf_q     <= '0;
      flt_q      <= FT_NONE;
    end else begin
      st_q       <= st_d;
      va_q       <= va_d;
      wr_q       <= wr_d;
      base_q     <= base_d;
      pt_frame_q <= pt_frame_d;
      sro_q      <= sro_d;
      leaf_q     <= leaf_d;
      flt_q      <= flt_d;
    end
  end

  // R8: busy walker never offers to take a request while a response waits
  a_r8_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R8: an unconsumed response keeps its contents
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable({rsp_flt_table, rsp_flt_page, rsp_flt_prot})));

  // R9: a stalled memory access keeps its address and direction
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata)));

  // R7: every write-back carries the referenced mark
  a_r7_wb_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> mem_wdata[LEAF_REF_BIT]);

  // R10: no response carries two faults
  a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_flt_table, rsp_flt_page, rsp_flt_prot}));

  // R11: memory is idle while the walker waits for work
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rsp_valid));

endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_super,
  input  logic              req_write,
  input  logic [ADDR_W-PAGE_W-1:0] sup_base,
  input  logic [ADDR_W-PAGE_W-1:0] usr_base,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_nocache,
  output logic              rsp_flt_table,
  output logic              rsp_flt_page,
  output logic              rsp_flt_prot,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata
);

  logic              dir_ok, dir_ro;
  fault_e            leaf_fault;
  logic [ADDR_W-1:0] leaf_next;
  logic              leaf_dirty;
  logic              cur_write, cur_seg_ro;

  xw_dir_check #(.WORD_W(ADDR_W), .PAGE_W(PAGE_W)) u_dir (
    .dir_word (mem_rdata),
    .dir_ok   (dir_ok),
    .dir_ro   (dir_ro)
  );

  xw_leaf_eval #(.WORD_W(ADDR_W)) u_leaf (
    .leaf_word  (mem_rdata),
    .is_write   (cur_write),
    .seg_ro     (cur_seg_ro),
    .leaf_fault (leaf_fault),
    .leaf_next  (leaf_next),
    .leaf_dirty (leaf_dirty)
  );

  xw_walk_ctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_super     (req_super),
    .req_write     (req_write),
    .sup_base      (sup_base),
    .usr_base      (usr_base),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .dir_ok        (dir_ok),
    .dir_ro        (dir_ro),
    .leaf_fault    (leaf_fault),
    .leaf_next     (leaf_next),
    .leaf_dirty    (leaf_dirty),
    .cur_write     (cur_write),
    .cur_seg_ro    (cur_seg_ro),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_nocache   (rsp_nocache),
    .rsp_flt_table (rsp_flt_table),
    .rsp_flt_page  (rsp_flt_page),
    .rsp_flt_prot  (rsp_flt_prot)
  );

endmodule

// File: tb/xlat_walk_bench.sv
`timescale 1ns/1ps
module xlat_walk_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_super, req_write;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [19:0] sup_base, usr_base;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_nocache, rsp_flt_table, rsp_flt_page, rsp_flt_prot;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  xlat_walk u_xlat_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_super(req_super), .req_write(req_write),
    .sup_base(sup_base), .usr_base(usr_base),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_nocache(rsp_nocache), .rsp_flt_table(rsp_flt_table),
    .rsp_flt_page(rsp_flt_page), .rsp_flt_prot(rsp_flt_prot),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic [2:0]  faults;   // {table, page, prot}
    logic [31:0] paddr;
    logic        nc;
    int          reads;
    int          writes;
    logic [31:0] wb_addr;
    logic [31:0] wb_val;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [31:0]];
  int          compared = 0;
  int          mismatched = 0;
  int          n_reads = 0;
  int          n_writes = 0;
  int          cyc = 0;
  bit          done = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr;
  bit          rhold_pend = 0;
  logic [31:0] rhold_paddr;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  // reference model built from the requirements
  function automatic exp_t model(input logic [31:0] va, input bit sup, input bit wr,
                                 input logic [19:0] sb_, input logic [19:0] ub_);
    exp_t e;
    logic [31:0] d, l, la, nv;
    e.faults = 3'b000; e.paddr = 0; e.nc = 0; e.writes = 0;
    e.wb_addr = 0; e.wb_val = 0;
    d = rd({sup ? sb_ : ub_, va[31:22], 2'b00});
    e.reads = 1;
    if (!(d[1] && d[3] && d[11:4] == 8'h00)) begin
      e.faults = 3'b100; e.tag = "R2"; return e;
    end
    la = {d[31:12], va[21:12], 2'b00};
    l = rd(la);
    e.reads = 2;
    if (!l[0]) begin e.faults = 3'b010; e.tag = "R4"; return e; end
    if (wr && (d[2] || l[2])) begin e.faults = 3'b001; e.tag = "R5"; return e; end
    e.paddr = {l[31:12], va[11:0]};
    e.nc = l[6];
    nv = l | 32'h8 | (wr ? 32'h10 : 32'h0);
    e.wb_addr = la;
    e.wb_val = nv;
    e.writes = (nv != l) ? 1 : 0;
    e.tag = "R6/R7";
    return e;
  endfunction

  // memory responder and response acceptor, all decided away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (hold_pend) begin
        check(mem_valid && mem_addr == hold_addr, "R9 stalled access held", mem_addr, hold_addr);
        hold_pend = 0;
      end
      if (rhold_pend) begin
        check(rsp_valid && rsp_paddr == rhold_paddr, "R8 response held", rsp_paddr, rhold_paddr);
        rhold_pend = 0;
      end
      mem_ready = (cyc % 3) != 1;
      mem_rdata = rd(mem_addr);
      if (mem_valid && mem_ready) begin
        if (mem_write) begin
          mem[mem_addr] = mem_wdata;
          n_writes++;
        end else n_reads++;
      end else if (mem_valid) begin
        hold_pend = 1; hold_addr = mem_addr;
      end
      rsp_ready = (cyc % 4) != 2;
      if (rsp_valid && !rsp_ready) begin
        rhold_pend = 1; rhold_paddr = rsp_paddr;
      end
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          check(0, "R8 unexpected response", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({rsp_flt_table, rsp_flt_page, rsp_flt_prot} == e.faults,
                {e.tag, " fault flags"},
                {29'd0, rsp_flt_table, rsp_flt_page, rsp_flt_prot}, {29'd0, e.faults});
          check(rsp_paddr == e.paddr, "R6 paddr", rsp_paddr, e.paddr);
          check(rsp_nocache == e.nc, "R6 nocache", {31'd0, rsp_nocache}, {31'd0, e.nc});
          check(n_reads == e.reads, "R2/R3 read count", n_reads, e.reads);
          check(n_writes == e.writes, "R7 write count", n_writes, e.writes);
          if (e.writes != 0)
            check(rd(e.wb_addr) == e.wb_val, "R7 written leaf", rd(e.wb_addr), e.wb_val);
        end
        n_reads = 0;
        n_writes = 0;
      end
    end
  end

  task automatic walk(input logic [9:0] di, input logic [9:0] li, input logic [11:0] off,
                      input bit sup, input bit wr, input bit scramble);
    logic [19:0] sb0, ub0;
    do @(negedge clk); while (sb.size() != 0 || !req_ready);
    req_vaddr = {di, li, off};
    req_super = sup;
    req_write = wr;
    req_valid = 1'b1;
    sb.push_back(model({di, li, off}, sup, wr, sup_base, usr_base));
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      sb0 = sup_base; ub0 = usr_base;
      sup_base = 20'hFFFFF; usr_base = 20'hFFFFF;   // R1: ignored mid-walk
      do @(negedge clk); while (sb.size() != 0);
      sup_base = sb0; usr_base = ub0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_super = 0; req_write = 0; req_vaddr = 0;
    rsp_ready = 0; mem_ready = 0; mem_rdata = 0;
    sup_base = 20'h00100; usr_base = 20'h00200;
    // supervisor directory
    mem[{20'h00100, 10'd0, 2'b00}] = 32'h0030000A;  // valid, points to 0x300
    mem[{20'h00100, 10'd1, 2'b00}] = 32'h00000000;  // invalid
    mem[{20'h00100, 10'd2, 2'b00}] = 32'h00300002;  // bit3 missing
    mem[{20'h00100, 10'd3, 2'b00}] = 32'h0030001A;  // reserved bit set
    mem[{20'h00100, 10'd4, 2'b00}] = 32'h0030000E;  // read-only segment
    // leaf page at frame 0x300
    mem[{20'h00300, 10'd1, 2'b00}] = 32'hABCDE001;
    mem[{20'h00300, 10'd2, 2'b00}] = 32'h12345049;
    mem[{20'h00300, 10'd3, 2'b00}] = 32'h55555005;
    mem[{20'h00300, 10'd4, 2'b00}] = 32'h00000000;
    mem[{20'h00300, 10'd5, 2'b00}] = 32'h66666019;
    // user directory, top slot
    mem[{20'h00200, 10'h3FF, 2'b00}] = 32'h0040000A;
    mem[{20'h00400, 10'h3FF, 2'b00}] = 32'h77777001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 req_ready after reset", {31'd0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'h0);
    check(mem_valid == 1'b0, "R11 mem_valid after reset", {31'd0, mem_valid}, 32'h0);

    walk(10'd0, 10'd1, 12'h123, 1, 0, 0);  // R7 read sets referenced, write-back
    walk(10'd0, 10'd1, 12'h456, 1, 0, 0);  // R7 already referenced, no write
    walk(10'd0, 10'd1, 12'hFFF, 1, 1, 0);  // R7 write sets modified
    walk(10'd0, 10'd5, 12'h000, 1, 1, 0);  // R7 both set already
    walk(10'd0, 10'd2, 12'h010, 1, 0, 0);  // R6 nocache
    walk(10'd0, 10'd3, 12'h020, 1, 1, 0);  // R5 read-only page write
    walk(10'd0, 10'd3, 12'h020, 1, 0, 0);  // R5 read of read-only page
    walk(10'd0, 10'd4, 12'h030, 1, 0, 0);  // R4 page fault
    walk(10'd1, 10'd1, 12'h040, 1, 0, 0);  // R2 invalid directory
    walk(10'd2, 10'd1, 12'h050, 1, 0, 0);  // R2 bit3 clear
    walk(10'd3, 10'd1, 12'h060, 1, 1, 0);  // R2 reserved bit
    walk(10'd4, 10'd1, 12'h070, 1, 1, 0);  // R5 read-only segment write
    walk(10'd4, 10'd5, 12'h080, 1, 0, 0);  // R5 read through read-only segment
    walk(10'h3FF, 10'h3FF, 12'hABC, 0, 0, 0); // R1 R3 user table top index
    walk(10'd0, 10'd1, 12'h111, 0, 0, 0);  // R1 user table slot 0 empty
    walk(10'd0, 10'd2, 12'h222, 1, 1, 1);  // R1 base changed mid-walk
    walk(10'h3FF, 10'h3FF, 12'h001, 0, 1, 1);  // R1 R7 user write, scrambled
    do @(negedge clk); while (sb.size() != 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule